// File: doc/BRIEF.md
# Transfer Counter and Byte FIFO Register File

This block is the host-facing register file of a SCSI-style bus controller. A byte-wide host port reaches a multi-byte transfer counter, a shallow byte FIFO behind a single address, a command register, and a set of status, interrupt, sequence-step and FIFO-level registers. The counter bytes that the host writes are held in a staging copy. They reach the live counter that the core sees only when a command arrives with its DMA bit set.

The core receives the live count, the DMA mode flag and the terminal-count flag. It can set terminal count, and it can load the interrupt and sequence-step registers. When the host issues a transfer-information command, the block computes the length of that transfer from the live count and the core's pending size, and hands that length to the core with a one-cycle strobe. Bus phase sequencing and data movement belong to other blocks.

With the default parameters the host addresses are as follows. Count bytes occupy addresses 0 (least significant), 1 and 2 (most significant). The FIFO is at 3 and the command register at 4. Status is at 5, interrupt at 6, sequence step at 7 and FIFO level at 8.

Top module: `xfer_regfile`

## Requirements
- R1: After reset the live count, the staged count, DMA mode, terminal count, the interrupt register, the sequence register and the FIFO level are all zero, and a read of the high count address (2) returns the chip identifier 8'hA2.
- R2: Reads of count addresses 0 and 1 return bytes 0 and 1 of the live count, and `cnt_value` is the live count with byte 0 least significant. A host write to a count address changes only the staged copy, so neither the readback nor `cnt_value` moves until a reload.
- R3: Status bit 4 is the terminal-count flag, also driven on `tc_flag`. `core_tc_set` sets it on the next edge. A host write to any count address clears it on the next edge. When both happen in the same cycle, the set wins.
- R4: Until the high count address has been written once since reset, a read of that address returns the chip identifier. After that first write, the read returns the live high byte.
- R5: A write to the command address with bit 7 set makes DMA mode 1 and copies all staged count bytes into the live count. A command write with bit 7 clear makes DMA mode 0 and leaves the live count unchanged. Status bit 7 and `dma_mode` report DMA mode.
- R6: A command whose low seven bits are 7'h10 pulses `xfer_go` for exactly one cycle, starting on the edge after the write. On that cycle `xfer_len` equals min(C, `pend_size`), where C is the live count after any reload by the same command, and a live count of zero stands for 2^24 with the default parameters.
- R7: A FIFO write stores the byte at the write position and advances it. When the write position equals depth-1 (15), the write is dropped. The FIFO level register (address 8) reads the write position minus the read position.
- R8: A FIFO read returns the stored bytes in write order. When the read position catches up with the write position, both positions return to zero.
- R9: A FIFO read while the FIFO is empty returns the byte most recently delivered by a FIFO read (zero after reset) and moves neither position.
- R10: A command whose low seven bits are 7'h01 (flush) sets the interrupt register to 8'h08, clears the sequence register and empties the FIFO, so the level reads 0.
- R11: `core_evt` loads `core_intr` into the interrupt register and `core_seq` into the sequence register on the next edge, except when a flush command falls in the same cycle, in which case the flush values win.
- R12: Reads of the command address, of addresses 9 to 15 and of any address with `bus_sel` low return 8'h00. Host writes to status, interrupt, sequence and level addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| core_tc_set | input | 1 | Core sets terminal count |
| core_evt | input | 1 | Core loads interrupt and sequence registers |
| core_intr | input | 8 | Interrupt value to load |
| core_seq | input | 8 | Sequence-step value to load |
| pend_size | input | 25 | Pending transfer size from the core |
| cnt_value | output | 24 | Live transfer count |
| dma_mode | output | 1 | DMA mode flag |
| tc_flag | output | 1 | Terminal-count flag |
| xfer_go | output | 1 | Transfer length valid strobe |
| xfer_len | output | 25 | Computed transfer length |

## Verification
The bench builds the block with its defaults: three count bytes, a 16-entry FIFO, identifier 8'hA2, and identifier readback enabled. The depth of 16 lets a 20-byte burst reach the depth-1 drop point, and the three-byte counter makes the zero-means-2^24 case reachable through plain writes. With these values the bench can show both outcomes of the min() selection, the identifier giving way after the first high-byte write, and the positions returning to zero after a partial drain.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
   // Offsets of the non-count registers, placed right after the count bytes
   localparam int OFS_FIFO  = 0;
   localparam int OFS_CMD   = 1;
   localparam int OFS_STAT  = 2;
   localparam int OFS_INTR  = 3;
   localparam int OFS_SEQ   = 4;
   localparam int OFS_LEVEL = 5;
   localparam int NUM_MISC  = 6;

   // Command byte layout
   localparam int          CMD_DMA_BIT = 7;
   localparam logic [6:0]  OP_FLUSH    = 7'h01;
   localparam logic [6:0]  OP_XFER     = 7'h10;

   // Status byte layout
   localparam int          STAT_DMA_BIT = 7;
   localparam int          STAT_TC_BIT  = 4;

   localparam logic [7:0]  INTR_FUNC_DONE = 8'h08;
endpackage

// File: rtl/xfr_count_bank.sv
module xfr_count_bank #(
   parameter int CNT_BYTES      = 3,
   parameter bit ID_UNTIL_WRITE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_BYTES-1:0]   wr_byte,
   input  logic [7:0]             wdata,
   input  logic                   reload,
   output logic [8*CNT_BYTES-1:0] cnt_live,
   output logic [8*CNT_BYTES-1:0] cnt_staged,
   output logic                   id_active
);
   localparam int CNT_W = 8 * CNT_BYTES;
   localparam int MSB   = CNT_BYTES - 1;

   logic [CNT_W-1:0] staged_q;
   logic [CNT_W-1:0] live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
      end else begin
         for (int i = 0; i < CNT_BYTES; i++) begin
            if (wr_byte[i]) staged_q[i*8 +: 8] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      live_q <= '0;
      else if (reload) live_q <= staged_q;
   end

   assign cnt_live   = live_q;
   assign cnt_staged = staged_q;

   generate
      if (ID_UNTIL_WRITE) begin : g_id
         logic hi_seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hi_seen_q <= 1'b0;
            else if (wr_byte[MSB]) hi_seen_q <= 1'b1;
         end
         assign id_active = !hi_seen_q;

         // R4: identifier readback ends only through a high-byte write
         a_r4_id_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(id_active) |-> $past(wr_byte[MSB]));
      end else begin : g_no_id
         assign id_active = 1'b0;
      end
   endgenerate

   // R5: the live count only moves on a reload
   a_r5_live_needs_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(live_q));
endmodule

// File: rtl/xfr_byte_fifo.sv
module xfr_byte_fifo #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic                     flush,
   input  logic [7:0]               din,
   output logic [7:0]               dout,
   output logic [$clog2(DEPTH)-1:0] level
);
   localparam int            PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [7:0]       hold_q;
   logic             has_data, push_ok;

   assign has_data = rptr_q < wptr_q;
   assign push_ok  = push && (wptr_q != LAST);
   assign dout     = has_data ? mem[rptr_q] : hold_q;
   assign level    = wptr_q - rptr_q;

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         hold_q <= '0;
      end else if (flush) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (push_ok) begin
         wptr_q <= wptr_q + 1'b1;
      end else if (pop && has_data) begin
         hold_q <= mem[rptr_q];
         if (rptr_q + 1'b1 == wptr_q) begin
            wptr_q <= '0;
            rptr_q <= '0;
         end else begin
            rptr_q <= rptr_q + 1'b1;
         end
      end
   end

   // R7: the write position never passes depth-1
   a_r7_wptr_cap: assert property (@(posedge clk) disable iff (!rst_n)
      wptr_q <= LAST);
   // R7: a write at depth-1 is dropped
   a_r7_drop_at_last: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && wptr_q == LAST) |=> $stable(wptr_q));
   // R8: the read position never overtakes the write position
   a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_q <= wptr_q);
   // R9: an empty read keeps both positions
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !flush && level == '0) |=> (level == '0 && $stable(hold_q)));
   // R10: flush empties the FIFO
   a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0);
endmodule

// File: rtl/xfr_len_calc.sv
module xfr_len_calc #(
   parameter int CNT_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W:0] pend,
   output logic           go,
   output logic [CNT_W:0] len
);
   logic [CNT_W:0] eff, len_d;

   assign eff   = (cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt};
   assign len_d = (eff < pend) ? eff : pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go  <= 1'b0;
         len <= '0;
      end else begin
         go <= start;
         if (start) len <= len_d;
      end
   end

   // R6: the strobe follows a command by one edge
   a_r6_go_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> $past(start));
   // R6: the length never exceeds the pending size
   a_r6_len_le_pend: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> len <= $past(pend));
endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile
   import xfr_pkg::*;
#(
   parameter int         ADDR_W         = 4,
   parameter int         CNT_BYTES      = 3,
   parameter int         FIFO_DEPTH     = 16,
   parameter logic [7:0] CHIP_ID        = 8'hA2,
   parameter bit         ID_UNTIL_WRITE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   input  logic                   core_tc_set,
   input  logic                   core_evt,
   input  logic [7:0]             core_intr,
   input  logic [7:0]             core_seq,
   input  logic [8*CNT_BYTES:0]   pend_size,
   output logic [8*CNT_BYTES-1:0] cnt_value,
   output logic                   dma_mode,
   output logic                   tc_flag,
   output logic                   xfer_go,
   output logic [8*CNT_BYTES:0]   xfer_len
);
   localparam int CNT_W = 8 * CNT_BYTES;
   localparam int LVL_W = $clog2(FIFO_DEPTH);
   localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(CNT_BYTES - 1);
   localparam logic [ADDR_W-1:0] A_FIFO  = ADDR_W'(CNT_BYTES + OFS_FIFO);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(CNT_BYTES + OFS_CMD);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(CNT_BYTES + OFS_STAT);
   localparam logic [ADDR_W-1:0] A_INTR  = ADDR_W'(CNT_BYTES + OFS_INTR);
   localparam logic [ADDR_W-1:0] A_SEQ   = ADDR_W'(CNT_BYTES + OFS_SEQ);
   localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(CNT_BYTES + OFS_LEVEL);

   initial begin
      a_cfg_cnt_bytes: assert (CNT_BYTES >= 2 && CNT_BYTES <= 4)
         else $error("CNT_BYTES out of range");
      a_cfg_depth: assert (FIFO_DEPTH >= 4 && FIFO_DEPTH <= 128)
         else $error("FIFO_DEPTH out of range");
      a_cfg_addr: assert (CNT_BYTES + NUM_MISC <= (1 << ADDR_W))
         else $error("ADDR_W too small for register map");
   end

   // ---------------- access decode ----------------
   logic                 wr_acc, rd_acc;
   logic [CNT_BYTES-1:0] wr_byte;
   logic                 cnt_wr_any, cmd_wr, reload, flush, xfer_start;
   logic                 fifo_push, fifo_pop;
   logic [6:0]           opcode;

   assign wr_acc = bus_sel && bus_we;
   assign rd_acc = bus_sel && !bus_we;

   generate
      for (genvar gi = 0; gi < CNT_BYTES; gi++) begin : g_wr_dec
         assign wr_byte[gi] = wr_acc && (bus_addr == ADDR_W'(gi));
      end
   endgenerate

   assign cnt_wr_any = |wr_byte;
   assign cmd_wr     = wr_acc && (bus_addr == A_CMD);
   assign opcode     = bus_wdata[6:0];
   assign reload     = cmd_wr && bus_wdata[CMD_DMA_BIT];
   assign flush      = cmd_wr && (opcode == OP_FLUSH);
   assign xfer_start = cmd_wr && (opcode == OP_XFER);
   assign fifo_push  = wr_acc && (bus_addr == A_FIFO);
   assign fifo_pop   = rd_acc && (bus_addr == A_FIFO);

   // ---------------- sub-blocks ----------------
   logic [CNT_W-1:0] cnt_live, cnt_staged, cnt_eff;
   logic             id_active;
   logic [7:0]       fifo_dout;
   logic [LVL_W-1:0] fifo_level;

   xfr_count_bank #(
      .CNT_BYTES      (CNT_BYTES),
      .ID_UNTIL_WRITE (ID_UNTIL_WRITE)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_byte    (wr_byte),
      .wdata      (bus_wdata),
      .reload     (reload),
      .cnt_live   (cnt_live),
      .cnt_staged (cnt_staged),
      .id_active  (id_active)
   );

   xfr_byte_fifo #(
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .pop   (fifo_pop),
      .flush (flush),
      .din   (bus_wdata),
      .dout  (fifo_dout),
      .level (fifo_level)
   );

   // The transfer command sees the count as reloaded by the same write
   assign cnt_eff = reload ? cnt_staged : cnt_live;

   xfr_len_calc #(
      .CNT_W (CNT_W)
   ) u_len (
      .clk   (clk),
      .rst_n (rst_n),
      .start (xfer_start),
      .cnt   (cnt_eff),
      .pend  (pend_size),
      .go    (xfer_go),
      .len   (xfer_len)
   );

   // ---------------- control and status registers ----------------
   logic       dma_q, tc_q;
   logic [7:0] intr_q, seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dma_q <= 1'b0;
      else if (cmd_wr) dma_q <= bus_wdata[CMD_DMA_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tc_q <= 1'b0;
      else if (core_tc_set) tc_q <= 1'b1;
      else if (cnt_wr_any)  tc_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intr_q <= '0;
         seq_q  <= '0;
      end else if (flush) begin
         intr_q <= INTR_FUNC_DONE;
         seq_q  <= '0;
      end else if (core_evt) begin
         intr_q <= core_intr;
         seq_q  <= core_seq;
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = 8'h00;
      if (rd_acc) begin
         for (int i = 0; i < CNT_BYTES; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = cnt_live[i*8 +: 8];
         end
         if (bus_addr == A_HI && id_active) bus_rdata = CHIP_ID;
         if (bus_addr == A_FIFO)  bus_rdata = fifo_dout;
         if (bus_addr == A_STAT) begin
            bus_rdata[STAT_DMA_BIT] = dma_q;
            bus_rdata[STAT_TC_BIT]  = tc_q;
         end
         if (bus_addr == A_INTR)  bus_rdata = intr_q;
         if (bus_addr == A_SEQ)   bus_rdata = seq_q;
         if (bus_addr == A_LEVEL) bus_rdata = 8'(fifo_level);
      end
   end

   assign cnt_value = cnt_live;
   assign dma_mode  = dma_q;
   assign tc_flag   = tc_q;

   // R3: a count write clears terminal count unless the core sets it
   a_r3_write_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_any && !core_tc_set) |=> !tc_flag);
   // R3: a core set always lands
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      core_tc_set |=> tc_flag);
   // R5: DMA mode follows the bit of the last command
   a_r5_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> dma_mode == $past(bus_wdata[CMD_DMA_BIT]));
   // R5: without a DMA-bit command the live count holds
   a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(cnt_value));
   // R10: flush wins over a core load
   a_r10_flush_intr: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (intr_q == INTR_FUNC_DONE && seq_q == 8'h00));
   // R12: no read data outside a read access
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |-> bus_rdata == 8'h00);
endmodule

// File: tb/xfer_regfile_bench.sv
`timescale 1ns/1ps
module xfer_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        tc_set = 1'b0, evt = 1'b0;
   logic [7:0]  evt_intr = '0, evt_seq = '0;
   logic [24:0] pend = '0;
   logic [23:0] cnt;
   logic        dma, tc, go;
   logic [24:0] len;

   always #10 clk = ~clk;

   xfer_regfile u_xfer_regfile (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (sel), .bus_we (we), .bus_addr (addr),
      .bus_wdata (wdata), .bus_rdata (rdata),
      .core_tc_set (tc_set), .core_evt (evt),
      .core_intr (evt_intr), .core_seq (evt_seq),
      .pend_size (pend), .cnt_value (cnt), .dma_mode (dma),
      .tc_flag (tc), .xfer_go (go), .xfer_len (len)
   );

   int vectors = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(string req, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  m_stg[3], m_live[3];
   bit  m_hiw, m_dma, m_tc, m_go;
   int  m_intr, m_seq, m_len, m_hold, m_wp, m_rp;
   int  m_mem[16];

   function automatic int m_count();
      return m_live[0] + (m_live[1] << 8) + (m_live[2] << 16);
   endfunction

   function automatic int m_read(int a);
      case (a)
         0, 1: return m_live[a];
         2:    return m_hiw ? m_live[2] : 'hA2;
         3:    return (m_rp < m_wp) ? m_mem[m_rp] : m_hold;
         5:    return (int'(m_dma) << 7) | (int'(m_tc) << 4);
         6:    return m_intr;
         7:    return m_seq;
         8:    return m_wp - m_rp;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_stg[i]) begin m_stg[i] = 0; m_live[i] = 0; end
         m_hiw = 0; m_dma = 0; m_tc = 0; m_go = 0;
         m_intr = 0; m_seq = 0; m_len = 0; m_hold = 0; m_wp = 0; m_rp = 0;
      end else begin
         automatic int  a = int'(addr);
         automatic int  d = int'(wdata);
         automatic bit  fl = 0;
         m_go = 0;
         if (tc_set) m_tc = 1;
         else if (sel && we && a < 3) m_tc = 0;
         if (sel && we) begin
            if (a < 3) begin
               m_stg[a] = d;
               if (a == 2) m_hiw = 1;
            end else if (a == 3) begin
               if (m_wp != 15) begin m_mem[m_wp] = d; m_wp++; end
            end else if (a == 4) begin
               m_dma = d[7];
               if (d[7]) foreach (m_stg[i]) m_live[i] = m_stg[i];
               if ((d & 'h7f) == 'h01) begin
                  fl = 1; m_intr = 'h08; m_seq = 0; m_wp = 0; m_rp = 0;
               end
               if ((d & 'h7f) == 'h10) begin
                  automatic longint c = m_count();
                  if (c == 0) c = 'h1000000;
                  m_len = int'((c < longint'(pend)) ? c : longint'(pend));
                  m_go = 1;
               end
            end
         end else if (sel && a == 3) begin
            if (m_rp < m_wp) begin m_hold = m_mem[m_rp]; m_rp++; end
            if (m_rp == m_wp) begin m_rp = 0; m_wp = 0; end
         end
         if (evt && !fl) begin m_intr = int'(evt_intr); m_seq = int'(evt_seq); end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2", "cnt_value", cnt, m_count());
         chk("R5", "dma_mode", dma, m_dma);
         chk("R3", "tc_flag", tc, m_tc);
         chk("R6", "xfer_go", go, m_go);
         if (m_go) chk("R6", "xfer_len", len, m_len);
         if (sel && !we) begin
            case (int'(addr))
               0, 1: chk("R2", "count byte read", rdata, m_read(int'(addr)));
               2:    chk("R4", "high count read", rdata, m_read(2));
               3:    chk("R8 R9", "fifo read", rdata, m_read(3));
               5:    chk("R3 R5", "status read", rdata, m_read(5));
               6, 7: chk("R10 R11", "intr/seq read", rdata, m_read(int'(addr)));
               8:    chk("R7", "level read", rdata, m_read(8));
               default: chk("R12", "unmapped read", rdata, 0);
            endcase
         end else begin
            chk("R12", "idle read data", rdata, 0);
         end
      end
   end

   // ---------------- stimulus helpers (start at posedge+1) ----------------
   task automatic wr(int a, int d);
      sel = 1; we = 1; addr = 4'(a); wdata = 8'(d);
      @(posedge clk); #1;
      sel = 0; we = 0;
   endtask

   task automatic rd_expect(int a, int exp, string req);
      sel = 1; we = 0; addr = 4'(a);
      @(negedge clk);
      chk(req, "directed read", rdata, exp);
      @(posedge clk); #1;
      sel = 0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      rd_expect(2, 'hA2, "R1");
      rd_expect(5, 0, "R1");
      rd_expect(8, 0, "R1");
      rd_expect(6, 0, "R1");
      chk("R1", "cnt_value after reset", cnt, 0);

      // R2: staged writes do not show before reload
      wr(0, 'h34); wr(1, 'h12);
      rd_expect(0, 0, "R2");
      chk("R2", "cnt_value before reload", cnt, 0);

      // R3: terminal count set, cleared by count write, set wins
      tc_set = 1; idle(1); tc_set = 0;
      rd_expect(5, 'h10, "R3");
      wr(1, 'h12);
      chk("R3", "tc cleared by count write", tc, 0);
      tc_set = 1; wr(0, 'h34); tc_set = 0;
      chk("R3", "tc set wins", tc, 1);

      // R4: identifier until first high write
      rd_expect(2, 'hA2, "R4");
      wr(2, 'h00);
      rd_expect(2, 'h00, "R4");

      // R5: reload only with DMA bit
      wr(4, 'h80);
      chk("R5", "reloaded count", cnt, 'h001234);
      chk("R5", "dma on", dma, 1);
      wr(0, 'hFF);
      wr(4, 'h00);
      chk("R5", "no reload without DMA bit", cnt, 'h001234);
      chk("R5", "dma off", dma, 0);

      // R6: transfer length selection
      pend = 25'h100; wr(4, 'h10);
      chk("R6", "len limited by pending", len, 'h100);
      pend = 25'h20000; wr(4, 'h10);
      chk("R6", "len limited by count", len, 'h1234);
      wr(0, 0); wr(1, 0); wr(2, 0);
      pend = 25'h1FFFFFF; wr(4, 'h90);
      chk("R6", "zero count means full range", len, 'h1000000);
      pend = 25'h5; wr(4, 'h10);
      chk("R6", "zero count vs small pending", len, 5);
      idle(1);
      chk("R6", "strobe one cycle", go, 0);

      // R7 R8 R9: FIFO
      wr(3, 'hA1); wr(3, 'hB2); wr(3, 'hC3);
      rd_expect(8, 3, "R7");
      rd_expect(3, 'hA1, "R8");
      rd_expect(3, 'hB2, "R8");
      rd_expect(3, 'hC3, "R8");
      rd_expect(8, 0, "R8");
      rd_expect(3, 'hC3, "R9");
      for (int i = 0; i < 20; i++) wr(3, 'h40 + i);
      rd_expect(8, 15, "R7");
      for (int i = 0; i < 5; i++) rd_expect(3, 'h40 + i, "R8");
      wr(3, 'hEE);
      rd_expect(8, 10, "R7");
      for (int i = 5; i < 15; i++) rd_expect(3, 'h40 + i, "R8");
      rd_expect(3, 'h4E, "R9");
      rd_expect(8, 0, "R9");

      // R11 then R10: core load, flush priority
      evt = 1; evt_intr = 'h55; evt_seq = 'h03; idle(1); evt = 0;
      rd_expect(6, 'h55, "R11");
      rd_expect(7, 'h03, "R11");
      wr(3, 1); wr(3, 2);
      evt = 1; evt_intr = 'h77; evt_seq = 'h06; wr(4, 'h01); evt = 0;
      rd_expect(6, 'h08, "R10");
      rd_expect(7, 0, "R10");
      rd_expect(8, 0, "R10");

      // R12: read-only and unmapped addresses
      wr(5, 'hFF); wr(6, 'hFF); wr(7, 'hFF); wr(8, 'hFF);
      rd_expect(6, 'h08, "R12");
      rd_expect(4, 0, "R12");
      rd_expect(12, 0, "R12");

      // mixed traffic, checked against the model every clock
      for (int n = 0; n < 600; n++) begin
         automatic int a = int'($urandom % 10);
         automatic int d = int'($urandom % 256);
         if (a == 4) begin
            automatic int pick = int'($urandom % 3);
            d = (d & 'h80) | ((pick == 0) ? 'h00 : (pick == 1) ? 'h01 : 'h10);
         end
         tc_set   = ($urandom % 8) == 0;
         evt      = ($urandom % 8) == 0;
         evt_intr = 8'($urandom);
         evt_seq  = 8'($urandom);
         pend     = 25'($urandom % 'h30000);
         sel = 1; we = ($urandom % 2) == 1; addr = 4'(a); wdata = 8'(d);
         @(posedge clk); #1;
         sel = 0; we = 0; tc_set = 0; evt = 0;
      end
      idle(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule